// File: doc/BRIEF.md
# TDM Timeslot Sequencer and Channel Mapper

This block derives every piece of serial-frame timing from the bit clock and an active-low frame pulse. The clock runs at twice the serial bit rate, so one bit cell spans two clocks. A slot holds eight bits (16 clocks) and a frame holds 32 slots (512 clocks). A single counter holds the position in the frame. On every falling edge of the frame pulse the counter is forced back to slot 0, phase 0, so the block follows an external frame reference without drift.

From the counter position the block produces four things:
- the byte address in the two-port buffer memory, which the transmit and receive shifters use;
- a flag marking slots that carry the fixed idle byte 0xFF;
- a per-slot load/store enable;
- two bus strobes for the case where the device drives the parallel bus itself. The first strobe covers the first half of each valid slot, and the delayed select covers its second half.

Two mappings are available. The direct mapping gives each of the 32 slots its own byte. The sparse mapping stuffs every fourth slot with the idle byte and packs the remaining 24 slots into bytes 0 to 23. The address is always given for the slot that comes next. This lets the byte be exchanged at the slot boundary.

Top module: `tdm_slot_seq`

## Requirements
- R1: While rst_ni is low, the frame position is slot 0, phase 0, and all outputs show the values that position gives for the current ch32_i.
- R2: When frame_ni is high at one rising clock edge and low at the next, the cycle after that edge is slot 0, phase 0. Without a pulse the position advances by one clock per cycle and wraps from slot 31, phase 15 back to slot 0, phase 0.
- R3: A frame_ni held low for many cycles resynchronises the position only once, at its falling edge.
- R4: In direct mode, during slot c, ram_addr_o equals (c+1) mod 32.
- R5: In sparse mode, idle_slot_o is high during slots 0, 4, 8, 12, 16, 20, 24 and 28 and low in all other slots. These are the slots that carry 0xFF.
- R6: In sparse mode, during slot c, let n = (c+1) mod 32. If n is not a multiple of 4, ram_addr_o equals n - n/4 - 1, so bytes 0 to 23 follow slot order. If n is a multiple of 4, ram_addr_o is 0.
- R7: chan_start_no is low during phases 0 to 7 (four bit cells) of every non-idle slot and is high otherwise.
- R8: dly_cs_no is low during phases 8 to 15 of every non-idle slot and is high otherwise.
- R9: xfer_en_o is high only during phase 15 of a slot whose successor is not idle.
- R10: During an idle slot, both bus strobes stay high.
- R11: ch32_i high selects the direct mapping and ch32_i low selects the sparse mapping. The choice applies from the cycle the input changes, without waiting for a frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, two cycles per bit cell |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Frame pulse, active low; its falling edge marks frame start |
| ch32_i | input | 1 | 1 = 32-slot direct mapping, 0 = 24-slot sparse mapping |
| ram_addr_o | output | 5 | Buffer byte address for the next slot |
| idle_slot_o | output | 1 | Current slot carries the idle byte 0xFF |
| chan_start_no | output | 1 | Active-low strobe for the first half of a valid slot |
| dly_cs_no | output | 1 | Active-low delayed select for the second half of a valid slot |
| xfer_en_o | output | 1 | Load/store enable in the last clock before a valid slot |

## Verification
All outputs are decoded directly from one position counter, so a wrong count shows up at the ports as strobes, transfer enables and addresses that are shifted in time. A shifted strobe or enable appears within one slot of 16 clocks. An error in frame-pulse handling shows in the first cycle after the pulse, where slot 0, phase 0 is expected. A mapping error shows on ram_addr_o or idle_slot_o in the first slot where the two mappings differ, which is at most four slots away. For this reason the bench compares every output in every cycle against an independent model of the frame position.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
  localparam int unsigned DEF_CLK_PER_BIT   = 2;
  localparam int unsigned DEF_BITS_PER_SLOT = 8;
  localparam int unsigned DEF_NUM_SLOTS     = 32;
  localparam int unsigned DEF_STUFF_EVERY   = 4;

  typedef enum logic {
    MAP_SPARSE = 1'b0,
    MAP_DIRECT = 1'b1
  } map_mode_e;
endpackage

// File: rtl/tdm_timebase.sv
`timescale 1ns/1ps
module tdm_timebase #(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned PH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic [PH_W-1:0]   phase_o
);
  localparam int unsigned CNT_W = SLOT_W + PH_W;

  logic             fp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fp_fall;

  assign fp_fall = fp_q & ~frame_ni;

  // power-of-two frame length: natural wrap of the counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      fp_q  <= frame_ni;
      cnt_q <= fp_fall ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign {slot_o, phase_o} = cnt_q;
endmodule

// File: rtl/tdm_addr_gen.sv
`timescale 1ns/1ps
module tdm_addr_gen #(
  parameter int unsigned SLOT_W      = 5,
  parameter int unsigned STUFF_EVERY = 4
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              sparse_i,
  output logic              cur_idle_o,
  output logic              next_idle_o,
  output logic [SLOT_W-1:0] next_addr_o
);
  localparam int unsigned STUFF_SH = $clog2(STUFF_EVERY);

  logic [SLOT_W-1:0] nxt;
  logic [SLOT_W-1:0] packed_addr;

  assign nxt = slot_i + SLOT_W'(1);

  assign cur_idle_o  = sparse_i && (slot_i[STUFF_SH-1:0] == '0);
  assign next_idle_o = sparse_i && (nxt[STUFF_SH-1:0] == '0);

  // drop one address per stuffed slot already passed, plus slot 0
  assign packed_addr = nxt - (nxt >> STUFF_SH) - SLOT_W'(1);

  always_comb begin
    if (!sparse_i)        next_addr_o = nxt;
    else if (next_idle_o) next_addr_o = '0;
    else                  next_addr_o = packed_addr;
  end
endmodule

// File: rtl/tdm_strobe_gen.sv
`timescale 1ns/1ps
module tdm_strobe_gen #(
  parameter int unsigned PH_W = 4
) (
  input  logic [PH_W-1:0] phase_i,
  input  logic            cur_idle_i,
  input  logic            next_idle_i,
  output logic            chan_start_no,
  output logic            dly_cs_no,
  output logic            xfer_en_o
);
  logic second_half;

  assign second_half   = phase_i[PH_W-1];
  assign chan_start_no = cur_idle_i | second_half;
  assign dly_cs_no     = cur_idle_i | ~second_half;
  assign xfer_en_o     = (&phase_i) & ~next_idle_i;
endmodule

// File: rtl/tdm_slot_seq.sv
`timescale 1ns/1ps
module tdm_slot_seq #(
  parameter int unsigned CLK_PER_BIT   = tdm_pkg::DEF_CLK_PER_BIT,
  parameter int unsigned BITS_PER_SLOT = tdm_pkg::DEF_BITS_PER_SLOT,
  parameter int unsigned NUM_SLOTS     = tdm_pkg::DEF_NUM_SLOTS,
  parameter int unsigned STUFF_EVERY   = tdm_pkg::DEF_STUFF_EVERY,
  localparam int unsigned SLOT_W       = $clog2(NUM_SLOTS),
  localparam int unsigned PH_W         = $clog2(CLK_PER_BIT * BITS_PER_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              ch32_i,
  output logic [SLOT_W-1:0] ram_addr_o,
  output logic              idle_slot_o,
  output logic              chan_start_no,
  output logic              dly_cs_no,
  output logic              xfer_en_o
);
  import tdm_pkg::*;

  logic [SLOT_W-1:0] slot;
  logic [PH_W-1:0]   phase;
  logic              sparse;
  logic              cur_idle;
  logic              next_idle;

  assign sparse = (map_mode_e'(ch32_i) == MAP_SPARSE);

  tdm_timebase #(
    .SLOT_W (SLOT_W),
    .PH_W   (PH_W)
  ) u_timebase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_ni (frame_ni),
    .slot_o   (slot),
    .phase_o  (phase)
  );

  tdm_addr_gen #(
    .SLOT_W      (SLOT_W),
    .STUFF_EVERY (STUFF_EVERY)
  ) u_addr_gen (
    .slot_i      (slot),
    .sparse_i    (sparse),
    .cur_idle_o  (cur_idle),
    .next_idle_o (next_idle),
    .next_addr_o (ram_addr_o)
  );

  tdm_strobe_gen #(
    .PH_W (PH_W)
  ) u_strobe_gen (
    .phase_i       (phase),
    .cur_idle_i    (cur_idle),
    .next_idle_i   (next_idle),
    .chan_start_no (chan_start_no),
    .dly_cs_no     (dly_cs_no),
    .xfer_en_o     (xfer_en_o)
  );

  assign idle_slot_o = cur_idle;
endmodule

// File: rtl/tdm_slot_seq_chk.sv
`timescale 1ns/1ps
module tdm_slot_seq_chk #(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned MAPPED = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_ni,
  input logic              ch32_i,
  input logic [SLOT_W-1:0] ram_addr_o,
  input logic              idle_slot_o,
  input logic              chan_start_no,
  input logic              dly_cs_no,
  input logic              xfer_en_o
);
  logic fp_q;
  logic fall_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fp_q <= 1'b1;
    else         fp_q <= frame_ni;
  end

  assign fall_now = fp_q & ~frame_ni;

  // R7 R8
  strobes_disjoint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!chan_start_no && !dly_cs_no));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_slot_o |-> (chan_start_no && dly_cs_no));

  // R11
  direct_no_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch32_i |-> !idle_slot_o);

  // R6
  sparse_addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch32_i |-> (ram_addr_o < SLOT_W'(MAPPED)));

  // R9
  xfer_next_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_en_o && !fall_now) |=> (!idle_slot_o || !$stable(ch32_i)));

  // R9
  xfer_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_en_o |=> !xfer_en_o);

  // R2
  resync_slot0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_now |=> (!chan_start_no || idle_slot_o));
endmodule

bind tdm_slot_seq tdm_slot_seq_chk #(
  .SLOT_W (SLOT_W),
  .MAPPED (NUM_SLOTS - NUM_SLOTS / STUFF_EVERY)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_ni      (frame_ni),
  .ch32_i        (ch32_i),
  .ram_addr_o    (ram_addr_o),
  .idle_slot_o   (idle_slot_o),
  .chan_start_no (chan_start_no),
  .dly_cs_no     (dly_cs_no),
  .xfer_en_o     (xfer_en_o)
);

// File: tb/tb_tdm_slot_seq.sv
`timescale 1ns/1ps
module tb_tdm_slot_seq;
  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic       ch32 = 1'b1;
  logic [4:0] ram_addr;
  logic       idle_slot, chan_start_n, dly_cs_n, xfer_en;

  typedef struct {
    int    addr;
    int    idle;
    int    cs_n;
    int    dcs_n;
    int    xfer;
    bit    c32;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   n_chk = 0;
  int   n_fail = 0;
  int   m_cnt = 0;
  bit   m_prev = 1'b1;
  bit   done = 1'b0;

  tdm_slot_seq dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .frame_ni      (frame_n),
    .ch32_i        (ch32),
    .ram_addr_o    (ram_addr),
    .idle_slot_o   (idle_slot),
    .chan_start_no (chan_start_n),
    .dly_cs_no     (dly_cs_n),
    .xfer_en_o     (xfer_en)
  );

  always #(CLK_T/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(int cnt, bit c32, string tag);
    exp_t e;
    int slot  = cnt / 16;
    int ph    = cnt % 16;
    int n     = (slot + 1) % 32;
    bit idle  = !c32 && (slot % 4 == 0);
    bit nidle = !c32 && (n % 4 == 0);
    e.addr  = c32 ? n : (nidle ? 0 : n - n / 4 - 1);
    e.idle  = idle;
    e.cs_n  = !(!idle && ph < 8);
    e.dcs_n = !(!idle && ph >= 8);
    e.xfer  = (ph == 15) && !nidle;
    e.c32   = c32;
    e.tag   = tag;
    return e;
  endfunction

  // driver: set inputs for the next edge, push the state expected after it
  task automatic drive(bit f, bit c32, string tag);
    frame_n = f;
    ch32    = c32;
    if (m_prev && !f) m_cnt = 0;
    else              m_cnt = (m_cnt + 1) % 512;
    m_prev = f;
    q.push_back(model(m_cnt, c32, tag));
    @(negedge clk);
  endtask

  task automatic run(int n, bit c32, string tag);
    for (int i = 0; i < n; i++) drive(1'b1, c32, tag);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #(CLK_T/4);
    if (q.size() > 0) begin
      cur = q.pop_front();
      check({cur.tag, cur.c32 ? " R4 addr" : " R6 addr"}, int'(ram_addr), cur.addr);
      check({cur.tag, " R5 idle"}, int'(idle_slot), cur.idle);
      check({cur.tag, " R7 chan_start"}, int'(chan_start_n), cur.cs_n);
      check({cur.tag, " R8 dly_cs"}, int'(dly_cs_n), cur.dcs_n);
      check({cur.tag, " R9 xfer"}, int'(xfer_en), cur.xfer);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    // R1: reset state, direct then sparse
    #(3*CLK_T);
    check("R1 reset addr", int'(ram_addr), 1);
    check("R1 reset idle", int'(idle_slot), 0);
    check("R1 reset chan_start", int'(chan_start_n), 0);
    check("R1 reset dly_cs", int'(dly_cs_n), 1);
    check("R1 reset xfer", int'(xfer_en), 0);
    ch32 = 1'b0;
    #(CLK_T);
    check("R1 R11 reset sparse idle", int'(idle_slot), 1);
    check("R1 R11 reset sparse addr", int'(ram_addr), 0);
    check("R1 R10 reset sparse chan_start", int'(chan_start_n), 1);

    @(negedge clk);
    rst_n = 1'b1;
    run(40, 1'b1, "R1 free run");
    drive(1'b0, 1'b1, "R2 align");
    run(1100, 1'b1, "R4 direct");
    drive(1'b0, 1'b0, "R2 align sparse");
    run(1100, 1'b0, "R10 sparse");
    run(213, 1'b0, "R2 pre resync");
    drive(1'b0, 1'b0, "R2 resync");
    run(600, 1'b0, "R2 after resync");
    for (int i = 0; i < 40; i++) drive(1'b0, 1'b1, "R3 held low");
    run(700, 1'b1, "R3 after held");
    drive(1'b0, 1'b1, "R2 wrap ref");
    run(511, 1'b1, "R2 wrap run");
    drive(1'b0, 1'b1, "R2 aligned pulse");
    run(300, 1'b0, "R11 to sparse");
    run(300, 1'b1, "R11 to direct");
    run(77, 1'b0, "R11 back sparse");
    repeat (3) @(negedge clk);
    report();
  end
endmodule